// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This controller sits in the scan-clock domain and runs the dynamic phase-adjust handshake of a PLL on behalf of user logic. A request carries a step count, a direction and a 3-bit target select. After the block accepts it, the block drives the direction and select lines to the PLL. For each step it raises a step strobe and keeps it high for a minimum number of cycles. It lowers the strobe only after the PLL's done line has dropped, and it counts the step only when done has risen again. This sequence repeats until the requested number of steps has been applied. One strobe always produces exactly one phase increment.

The request side is a valid/ready port. `req_ready` is high only while the sequencer is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. While a run is in progress, `req_ready` stays low. This is the only back-pressure: a requester must hold `req_valid` and its fields until it sees `req_ready`. Each run ends with a one-cycle completion pulse, or with a one-cycle error pulse and an error code. The error cases are a reserved select code and a done line that fails to move within the programmable timeout.

The done input changes without reference to the scan clock. For that reason it passes through a two-flop synchronizer before the state machine uses it.

Top module: `phase_step_seq`

## Requirements
- R1: `pll_updown` and `pll_cntsel` take the accepted request's direction and select on the accept edge. They are valid at least one cycle before `pll_step` rises, and they do not change while `pll_step` is high.
- R2: Every strobe that ends normally stays high for at least MIN_HIGH cycles (default 2).
- R3: A strobe that ends normally is lowered only after the synchronized done line has been seen low.
- R4: A step counts as complete only when synchronized done is high again after the strobe has been lowered. The next strobe does not rise before that, and `steps_done` increments once per completed step.
- R5: A request for N steps produces exactly N strobes. For example, 40 steps of 125 ps each add up to a 5000 ps shift, which is half a period of a 100 MHz clock.
- R6: The select encoding is 3'b000 for all output counters, 3'b001 for the feedback counter, and 3'b010 through 3'b110 for output counters 0 to 4. The code appears unchanged on `pll_cntsel`.
- R7: A request with select 3'b111 is consumed. It produces a one-cycle `err_pulse` with `err_code` 2'b01 and no strobe, whatever its count.
- R8: `req_ready` is high exactly when the block is idle. A request with a count of zero and a legal select is consumed with no strobe, pulse or status change.
- R9: While the strobe is high and synchronized done stays high for `tmo_limit` cycles, the run aborts with `err_code` 2'b10. While waiting for done to rise and it stays low for `tmo_limit` cycles, the run aborts with 2'b11. An abort drops the strobe, pulses `err_pulse` and returns to idle.
- R10: After the last step completes, `done_pulse` is high for exactly one cycle, and at that point `steps_done` equals the requested count.
- R11: After reset, `req_ready` is 1. `busy`, `pll_step`, `done_pulse`, `err_pulse` and `steps_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_count | input | CNT_W | Number of steps |
| req_up | input | 1 | Direction: 1 up, 0 down |
| req_sel | input | 3 | Target counter select |
| tmo_limit | input | TMO_W | Timeout, in cycles, for each done edge |
| pll_updown | output | 1 | Direction to PLL |
| pll_cntsel | output | 3 | Counter select to PLL |
| pll_step | output | 1 | Phase step strobe |
| pll_done | input | 1 | Done from PLL (asynchronous) |
| busy | output | 1 | A run is in progress |
| done_pulse | output | 1 | One-cycle end-of-run pulse |
| err_pulse | output | 1 | One-cycle error pulse |
| err_code | output | 2 | Error cause, valid with `err_pulse` |
| steps_done | output | CNT_W | Steps completed in the current or last run |

## Verification
The assertions assume the PLL side behaves as a four-phase partner. Done is high whenever no strobe is pending, it never drops on its own, and once it has dropped it stays low until the strobe has been lowered. The bench's behavioural responder keeps to this. It lowers done only after it has seen the strobe, and raises it only after it has seen the strobe fall, each with a configurable delay. To reach the timeout paths, the responder is muted on one of its two edges, and after a muted rise it is released so that done returns high. Requests are driven between clock edges and held until accepted, so no field changes on a sampling edge.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_WAIT_HI = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'b00,
    ERR_RESERVED = 2'b01,
    ERR_FALL_TMO = 2'b10,
    ERR_RISE_TMO = 2'b11
  } seq_err_t;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_RESERVED = 3'b111;
endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pss_req_stage.sv
module pss_req_stage
  import pss_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] req_count,
  input  logic             req_up,
  input  logic [SEL_W-1:0] req_sel,
  output logic             start,
  output logic             reject,
  output logic [CNT_W-1:0] lat_count,
  output logic             lat_up,
  output logic [SEL_W-1:0] lat_sel
);
  logic take;

  assign req_ready = idle;
  assign take      = req_valid && req_ready;
  assign reject    = take && (req_sel == SEL_RESERVED);
  assign start     = take && !reject && (req_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_count <= '0;
      lat_up    <= 1'b0;
      lat_sel   <= '0;
    end else if (start) begin
      lat_count <= req_count;
      lat_up    <= req_up;
      lat_sel   <= req_sel;
    end
  end
endmodule

// File: rtl/pss_timer.sv
module pss_timer #(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;
  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clr)                      cnt <= '0;
    else if (run && (cnt != CNT_MAX))  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);
endmodule

// File: rtl/pss_step_fsm.sv
module pss_step_fsm
  import pss_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MIN_HIGH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reject,
  input  logic [CNT_W-1:0] count_in,
  input  logic             done_s,
  input  logic             tmo_exp,
  output logic             idle,
  output logic             busy,
  output logic             step,
  output logic             tmr_clr,
  output logic             tmr_run,
  output logic [CNT_W-1:0] steps_done,
  output logic             done_pulse,
  output logic             err_pulse,
  output logic [1:0]       err_code
);
  localparam int HI_W = $clog2(MIN_HIGH + 1);
  localparam logic [HI_W-1:0] HI_LAST = HI_W'(MIN_HIGH - 1);
  localparam logic [HI_W-1:0] HI_MAX  = '1;

  seq_state_t       state_q, state_d;
  logic [HI_W-1:0]  hi_cnt;
  logic [CNT_W-1:0] remaining;
  logic             fall_ok, fall_tmo, rise_ok, rise_tmo, last_step;

  assign fall_ok   = (state_q == ST_STROBE) && !done_s && (hi_cnt >= HI_LAST);
  assign fall_tmo  = (state_q == ST_STROBE) && done_s && tmo_exp;
  assign rise_ok   = (state_q == ST_WAIT_HI) && done_s;
  assign rise_tmo  = (state_q == ST_WAIT_HI) && !done_s && tmo_exp;
  assign last_step = (remaining == CNT_W'(1));

  always_comb begin
    state_d = state_q;
    tmr_clr = 1'b0;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = ST_SETUP;
      ST_SETUP: begin
        state_d = ST_STROBE;
        tmr_clr = 1'b1;
      end
      ST_STROBE: begin
        if (fall_ok) begin
          state_d = ST_WAIT_HI;
          tmr_clr = 1'b1;
        end else if (fall_tmo) begin
          state_d = ST_IDLE;
        end
      end
      ST_WAIT_HI: begin
        if (rise_ok)       state_d = last_step ? ST_IDLE : ST_SETUP;
        else if (rise_tmo) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_run = (state_q == ST_STROBE) || (state_q == ST_WAIT_HI);
  assign idle    = (state_q == ST_IDLE);
  assign busy    = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step       <= 1'b0;
      hi_cnt     <= '0;
      remaining  <= '0;
      steps_done <= '0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      err_code   <= ERR_NONE;
    end else begin
      state_q    <= state_d;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            remaining  <= count_in;
            steps_done <= '0;
            err_code   <= ERR_NONE;
          end else if (reject) begin
            err_pulse <= 1'b1;
            err_code  <= ERR_RESERVED;
          end
        end
        ST_SETUP: begin
          step   <= 1'b1;
          hi_cnt <= '0;
        end
        ST_STROBE: begin
          if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
          if (fall_ok) begin
            step <= 1'b0;
          end else if (fall_tmo) begin
            step      <= 1'b0;
            err_pulse <= 1'b1;
            err_code  <= ERR_FALL_TMO;
          end
        end
        ST_WAIT_HI: begin
          if (rise_ok) begin
            steps_done <= steps_done + 1'b1;
            remaining  <= remaining - 1'b1;
            if (last_step) done_pulse <= 1'b1;
          end else if (rise_tmo) begin
            err_pulse <= 1'b1;
            err_code  <= ERR_RISE_TMO;
          end
        end
        default: step <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int CNT_W    = 16,
  parameter int TMO_W    = 12,
  parameter int MIN_HIGH = 2,
  parameter int SYNC_N   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] req_count,
  input  logic             req_up,
  input  logic [2:0]       req_sel,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             pll_updown,
  output logic [2:0]       pll_cntsel,
  output logic             pll_step,
  input  logic             pll_done,
  output logic             busy,
  output logic             done_pulse,
  output logic             err_pulse,
  output logic [1:0]       err_code,
  output logic [CNT_W-1:0] steps_done
);
  logic             done_s, idle, start, reject;
  logic             tmr_clr, tmr_run, tmo_exp;
  logic [CNT_W-1:0] lat_count;

  pss_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pll_done), .sync_out(done_s)
  );

  pss_req_stage #(.CNT_W(CNT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_count(req_count), .req_up(req_up), .req_sel(req_sel),
    .start(start), .reject(reject),
    .lat_count(lat_count), .lat_up(pll_updown), .lat_sel(pll_cntsel)
  );

  pss_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .limit(tmo_limit), .expired(tmo_exp)
  );

  pss_step_fsm #(.CNT_W(CNT_W), .MIN_HIGH(MIN_HIGH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .reject(reject),
    .count_in(req_count), .done_s(done_s), .tmo_exp(tmo_exp),
    .idle(idle), .busy(busy), .step(pll_step),
    .tmr_clr(tmr_clr), .tmr_run(tmr_run),
    .steps_done(steps_done), .done_pulse(done_pulse),
    .err_pulse(err_pulse), .err_code(err_code)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int CNT_W    = 16,
  parameter int MIN_HIGH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pll_step,
  input logic             pll_updown,
  input logic [2:0]       pll_cntsel,
  input logic             done_s,
  input logic             busy,
  input logic             done_pulse,
  input logic             err_pulse,
  input logic [CNT_W-1:0] steps_done,
  input logic [CNT_W-1:0] lat_count
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_len <= '0;
    else if (!pll_step)                  run_len <= '0;
    else if (run_len != 8'hFF)           run_len <= run_len + 1'b1;
  end

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pll_step |-> ($stable(pll_cntsel) && $stable(pll_updown))); // R1
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_step) && !err_pulse) |-> (run_len >= 8'(MIN_HIGH))); // R2
  AST_FALL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pll_step) && !err_pulse) |-> !$past(done_s)); // R3
  AST_RISE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_step) |-> done_s); // R4
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    pll_step |-> (pll_cntsel != 3'b111)); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (!pll_step && !busy)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R10
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (steps_done == lat_count)); // R10
endmodule

bind phase_step_seq pss_checker #(.CNT_W(CNT_W), .MIN_HIGH(MIN_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_step(pll_step), .pll_updown(pll_updown),
  .pll_cntsel(pll_cntsel), .done_s(done_s), .busy(busy),
  .done_pulse(done_pulse), .err_pulse(err_pulse),
  .steps_done(steps_done), .lat_count(lat_count)
);

// File: tb/test_phase_step_seq.sv
`timescale 1ns/1ps
module test_phase_step_seq;
  localparam int CNT_W = 16;
  localparam int TMO_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [CNT_W-1:0] req_count = '0;
  logic             req_up = 1'b0;
  logic [2:0]       req_sel = '0;
  logic [TMO_W-1:0] tmo_limit = 12'd50;
  logic             pll_updown, pll_step, busy, done_pulse, err_pulse;
  logic [2:0]       pll_cntsel;
  logic             pll_done = 1'b1;
  logic [1:0]       err_code;
  logic [CNT_W-1:0] steps_done;

  always #2.5 clk = ~clk;

  phase_step_seq #(.CNT_W(CNT_W), .TMO_W(TMO_W)) i_phase_step_seq (.*);

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  typedef struct {
    bit is_err;
    int code;
    int count;
    int base;
  } exp_t;
  exp_t sb_q[$];

  // Behavioural responder standing in for the PLL
  int  fall_dly = 1, rise_dly = 1;
  bit  mute_fall = 0, mute_rise = 0;
  int  strobe_cnt = 0;
  int  net [8];
  int  rs = 0, wait_c = 0, width = 0;
  logic [2:0] seen_sel;
  logic       seen_up;
  logic [2:0] exp_sel;

  initial begin
    for (int i = 0; i < 8; i++) net[i] = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pll_step) begin
          width++;
          if (width > 1)
            check(pll_cntsel == seen_sel && pll_updown == seen_up, "R1 select held",
                  int'(pll_cntsel), int'(seen_sel));
        end else if (width != 0) begin
          if (!err_pulse) check(width >= 2, "R2 strobe width", width, 2);
          width = 0;
        end
        case (rs)
          0: if (pll_step) begin
               strobe_cnt++;
               seen_sel = pll_cntsel;
               seen_up  = pll_updown;
               check(pll_cntsel == exp_sel, "R6 select code", int'(pll_cntsel), int'(exp_sel));
               net[pll_cntsel] += pll_updown ? 1 : -1;
               wait_c = 0;
               rs = 1;
             end
          1: begin
               if (!pll_step) begin
                 check(err_pulse, "R3 strobe dropped with done high", 0, 1);
                 rs = 0;
               end else if (!mute_fall) begin
                 if (wait_c >= fall_dly) begin pll_done = 1'b0; rs = 2; end
                 else wait_c++;
               end
             end
          2: if (!pll_step) begin wait_c = 0; rs = 3; end
          3: begin
               if (pll_step) check(0, "R4 strobe before done high", 1, 0);
               if (!mute_rise) begin
                 if (wait_c >= rise_dly) begin pll_done = 1'b1; rs = 0; end
                 else wait_c++;
               end
             end
          default: rs = 0;
        endcase
      end
    end
  end

  // Monitor: compares end-of-run results against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (done_pulse || err_pulse)) begin
        if (sb_q.size() == 0) begin
          check(0, "R8 unexpected end pulse", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(err_pulse == e.is_err, "R10 end kind", int'(err_pulse), int'(e.is_err));
          if (e.is_err) begin
            check(int'(err_code) == e.code, "R9 error code", int'(err_code), e.code);
            if (e.code == 1)
              check(strobe_cnt == e.base, "R7 no strobe", strobe_cnt - e.base, 0);
          end else begin
            check(int'(steps_done) == e.count, "R10 steps_done", int'(steps_done), e.count);
            check(strobe_cnt - e.base == e.count, "R5 strobe count",
                  strobe_cnt - e.base, e.count);
          end
          @(negedge clk);
          check(!done_pulse && !err_pulse, "R10 single pulse", int'(done_pulse), 0);
        end
      end
    end
  end

  task automatic issue(input int cnt, input bit up, input logic [2:0] sel);
    @(negedge clk);
    req_valid = 1'b1; req_count = CNT_W'(cnt); req_up = up; req_sel = sel;
    exp_sel = sel;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic push(input bit is_err, input int code, input int cnt);
    exp_t e;
    e.is_err = is_err; e.code = code; e.count = cnt; e.base = strobe_cnt;
    sb_q.push_back(e);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((busy || sb_q.size() != 0) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    check(guard < 5000, "R8 run finished", guard, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int base, n3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(req_ready && !busy && !pll_step && !done_pulse && !err_pulse && steps_done == 0,
          "R11 reset state", int'(busy), 0);

    // One step up on output counter 0 (code 010)
    push(0, 0, 1); issue(1, 1'b1, 3'b010); wait_idle();
    check(net[2] == 1, "R6 counter0 net", net[2], 1);

    // Three steps down on all counters (000); request while busy ignored (R8)
    fall_dly = 3; rise_dly = 0;
    n3 = net[3];
    push(0, 0, 3); issue(3, 1'b0, 3'b000);
    repeat (4) @(negedge clk);
    check(!req_ready && busy, "R8 ready low while busy", int'(req_ready), 0);
    req_valid = 1'b1; req_count = 16'd5; req_sel = 3'b011;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    check(net[0] == -3, "R5 all-counter net", net[0], -3);
    check(net[3] == n3, "R8 busy request ignored", net[3], n3);

    // Worked case: 40 up steps of 125 ps on feedback counter (001)
    fall_dly = 0; rise_dly = 2;
    push(0, 0, 40); issue(40, 1'b1, 3'b001); wait_idle();
    check(net[1] * 125 == 5000, "R5 40 steps = 5000 ps", net[1] * 125, 5000);

    // Reserved select rejected
    base = strobe_cnt;
    push(1, 1, 0); issue(4, 1'b1, 3'b111); wait_idle();
    check(strobe_cnt == base, "R7 reserved no strobe", strobe_cnt - base, 0);

    // Zero count consumed silently
    base = strobe_cnt;
    issue(0, 1'b1, 3'b100);
    repeat (6) @(negedge clk);
    check(!busy && strobe_cnt == base && steps_done == 40, "R8 zero count no effect",
          strobe_cnt - base, 0);

    // Output counter 4 (110), two steps down
    push(0, 0, 2); issue(2, 1'b0, 3'b110); wait_idle();
    check(net[6] == -2, "R6 counter4 net", net[6], -2);

    // Fall timeout
    mute_fall = 1;
    push(1, 2, 0); issue(2, 1'b1, 3'b011); wait_idle();
    check(!pll_step && req_ready, "R9 idle after fall timeout", int'(pll_step), 0);
    mute_fall = 0;

    // Rise timeout
    mute_rise = 1;
    push(1, 3, 0); issue(2, 1'b1, 3'b101); wait_idle();
    check(!pll_step && req_ready, "R9 idle after rise timeout", int'(pll_step), 0);
    mute_rise = 0;
    repeat (6) @(negedge clk);

    // Recovery run after errors
    push(0, 0, 2); issue(2, 1'b1, 3'b101); wait_idle();
    check(steps_done == 2, "R4 steps after recovery", int'(steps_done), 2);

    report();
  end
endmodule